// File: doc/BRIEF.md
# Power Monitor Serial Register Slave

This block is the two-wire serial slave of a power-monitoring controller. It watches SCL and SDA, oversampled by the chip clock, and pulls SDA low to acknowledge or to send data. A host selects a register with a command byte and writes or reads one byte. Three registers are read-only and carry live values from elsewhere in the chip: the fault flags, the source-voltage ADC code and the auxiliary-input ADC code. Two registers are writable: the control byte and a pin-configuration byte.

The slave's own address is a fixed five-bit prefix followed by two strap inputs. The slave also answers a broadcast write address that every device on the bus shares, and a control bit can switch that off. Fault events raise an alert request, which pulls a shared alert pin low. A host that sees the pin low reads the alert-response address. The slave answers with its own address only when it has a pending alert, and then drops its request. A bit in the pin-configuration byte can also pull the same pin low as a plain output. That bit alone never makes the slave answer.

Top module: `smb_mon_slave`

## Requirements
- R1: The own address is {5'b10001, adr_sel}. A write or read to that address is acknowledged. Any address that matches none of the accepted ones is not acknowledged, and nothing changes.
- R2: After reset, the control byte (command 00h) is 10h and the pin-configuration byte (command 03h) is 00h. A byte write to 00h or 03h stores the data. ctrl_bits shows the control byte, and ctrl_bits changes only while SCL is low.
- R3: A second data byte in the same write is acknowledged and discarded.
- R4: A read (command write, repeated START, address with R/W=1) returns the selected byte. Command 04h gives fault_flags, 05h gives source_code, 06h gives adin_code, and 00h and 03h give the stored bytes.
- R5: Any other command code reads as 00h. A write to such a code is acknowledged and has no effect.
- R6: Address 5Fh with R/W=0 is acknowledged and writes like the own address only while control bit 4 is 1. When that bit is 0 the address is not acknowledged and no register changes.
- R7: A one-cycle pulse on fault_evt sets the alert request. alert_pull is high while the request is set or pin-configuration bit 6 is 1.
- R8: Address 0Ch with R/W=1 is acknowledged while the alert request is set. The slave then sends {own address, 0}. At the end of that byte the request clears.
- R9: Address 0Ch is not acknowledged when no alert request is set, even while bit 6 holds alert_pull high.
- R10: A fault_evt pulse in the same cycle as the clear of R8 leaves the request set.
- R11: START and STOP are SDA edges while SCL is high. A STOP part-way through a byte returns the slave to idle, and the next transaction works. sda_pull only rises while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | SCL level seen on the pin |
| sda_in | input | 1 | SDA level seen on the pin |
| sda_pull | output | 1 | 1 pulls SDA low |
| adr_sel | input | 2 | Address strap, low two address bits |
| fault_flags | input | 8 | Live fault flags, read at 04h |
| source_code | input | 8 | Source-voltage ADC code, read at 05h |
| adin_code | input | 8 | Auxiliary-input ADC code, read at 06h |
| fault_evt | input | 1 | One-cycle fault event, sets the alert request |
| ctrl_bits | output | 8 | Current control byte |
| alert_pull | output | 1 | 1 pulls the shared alert pin low |

## Verification
Two actions can fall in the same clock cycle. One is the clear of the alert request at the end of the alert-response byte. The other is a new fault event. The bench drives fault_evt for exactly the cycle in which the synchronised falling edge of SCL after the eighth sent bit reaches the slave's state. After the transaction it expects alert_pull to stay high. A separate run with no event expects alert_pull to drop, so a design where the clear takes priority fails one case and a design that never clears fails the other.

// File: rtl/smb_mon_slave.sv
`timescale 1ns/1ps
module smb_mon_slave #(
  parameter logic [4:0] ADDR_BASE = 5'b10001,
  parameter logic [6:0] MASS_ADDR = 7'h5F,
  parameter logic [6:0] ARA_ADDR  = 7'h0C,
  parameter logic [7:0] CTRL_RST  = 8'h10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_pull,
  input  logic [1:0] adr_sel,
  input  logic [7:0] fault_flags,
  input  logic [7:0] source_code,
  input  logic [7:0] adin_code,
  input  logic       fault_evt,
  output logic [7:0] ctrl_bits,
  output logic       alert_pull
);
  typedef enum logic [2:0] {S_IDLE = 3'd0, S_ADDR, S_CMD, S_WR, S_TX, S_IGN} st_t;

  logic [2:0] scl_sy, sda_sy;
  st_t        st;
  logic [3:0] cnt;
  logic       ackph, mph, mack, ara_q, wr_done, drive, pend;
  logic [7:0] shreg, txsh, cmd_q, ctrl_q, pin_q, rd_val;
  logic       rise, fall, start_c, stop_c, clr;
  logic [6:0] own;

  assign own     = {ADDR_BASE, adr_sel};
  assign rise    = scl_sy[1] & ~scl_sy[2];
  assign fall    = ~scl_sy[1] & scl_sy[2];
  assign start_c = scl_sy[1] & scl_sy[2] & ~sda_sy[1] & sda_sy[2];
  assign stop_c  = scl_sy[1] & scl_sy[2] & sda_sy[1] & ~sda_sy[2];
  assign clr     = (st == S_TX) && !ackph && !mph && fall && (cnt == 4'd8) && ara_q;

  assign sda_pull   = drive;
  assign ctrl_bits  = ctrl_q;
  assign alert_pull = pend | pin_q[6];

  always_comb begin
    case (cmd_q)
      8'h00:   rd_val = ctrl_q;
      8'h03:   rd_val = pin_q;
      8'h04:   rd_val = fault_flags;
      8'h05:   rd_val = source_code;
      8'h06:   rd_val = adin_code;
      default: rd_val = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 3'b111;
      sda_sy <= 3'b111;
      pend   <= 1'b0;
    end else begin
      scl_sy <= {scl_sy[1:0], scl_in};
      sda_sy <= {sda_sy[1:0], sda_in};
      pend   <= fault_evt | (pend & ~clr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; ackph <= 1'b0; mph <= 1'b0; mack <= 1'b0;
      ara_q <= 1'b0; wr_done <= 1'b0; drive <= 1'b0;
      shreg <= '0; txsh <= '0; cmd_q <= '0; ctrl_q <= CTRL_RST; pin_q <= '0;
    end else if (start_c) begin
      st <= S_ADDR; cnt <= '0; ackph <= 1'b0; mph <= 1'b0; drive <= 1'b0; ara_q <= 1'b0;
    end else if (stop_c) begin
      st <= S_IDLE; ackph <= 1'b0; mph <= 1'b0; drive <= 1'b0;
    end else if (ackph) begin
      if (fall) begin
        ackph <= 1'b0;
        cnt   <= '0;
        drive <= (st == S_TX) ? ~txsh[7] : 1'b0;
      end
    end else begin
      case (st)
        S_ADDR, S_CMD, S_WR: begin
          if (rise) begin
            shreg <= {shreg[6:0], sda_sy[1]};
            cnt   <= cnt + 4'd1;
          end
          if (fall && cnt == 4'd8) begin
            if (st == S_ADDR) begin
              wr_done <= 1'b0;
              if (shreg[7:1] == own) begin
                drive <= 1'b1; ackph <= 1'b1;
                st    <= shreg[0] ? S_TX : S_CMD;
                txsh  <= rd_val;
              end else if (shreg[7:1] == MASS_ADDR && !shreg[0] && ctrl_q[4]) begin
                drive <= 1'b1; ackph <= 1'b1; st <= S_CMD;
              end else if (shreg[7:1] == ARA_ADDR && shreg[0] && pend) begin
                drive <= 1'b1; ackph <= 1'b1; st <= S_TX;
                txsh  <= {own, 1'b0}; ara_q <= 1'b1;
              end else begin
                st <= S_IGN;
              end
            end else if (st == S_CMD) begin
              cmd_q <= shreg; drive <= 1'b1; ackph <= 1'b1; st <= S_WR;
            end else begin
              drive <= 1'b1; ackph <= 1'b1;
              if (!wr_done) begin
                wr_done <= 1'b1;
                if (cmd_q == 8'h00) ctrl_q <= shreg;
                if (cmd_q == 8'h03) pin_q  <= shreg;
              end
            end
          end
        end
        S_TX: begin
          if (mph) begin
            if (rise) mack <= ~sda_sy[1];
            if (fall) begin
              mph <= 1'b0;
              if (mack) begin drive <= ~txsh[7]; cnt <= '0; end
              else st <= S_IGN;
            end
          end else begin
            if (rise) cnt <= cnt + 4'd1;
            if (fall && cnt != 4'd0) begin
              txsh <= {txsh[6:0], txsh[7]};
              if (cnt == 4'd8) begin drive <= 1'b0; mph <= 1'b1; end
              else drive <= ~txsh[6];
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/smb_mon_slave_chk.sv
`timescale 1ns/1ps
module smb_mon_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_in,
  input logic       sda_pull,
  input logic       fault_evt,
  input logic       alert_pull,
  input logic [7:0] ctrl_bits,
  input logic [2:0] st_v
);
  assert_sda_rise_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_in);
  assert_idle_released_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_v == 3'd0) |-> !sda_pull);
  assert_ctrl_moves_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_bits) |-> !scl_in);
  assert_evt_raises_alert_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> alert_pull);
  assert_evt_beats_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alert_pull) |-> !$past(fault_evt));
endmodule

bind smb_mon_slave smb_mon_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_pull(sda_pull),
  .fault_evt(fault_evt), .alert_pull(alert_pull), .ctrl_bits(ctrl_bits), .st_v(st)
);

// File: tb/test_smb_mon_slave.sv
`timescale 1ns/1ps
module test_smb_mon_slave;
  localparam int Q = 8;
  localparam logic [6:0] OWN = 7'h46;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_sda = 1'b1, fault_evt = 1'b0;
  logic [7:0] fault_flags = 8'h21, source_code = 8'h9C, adin_code = 8'h3D;
  logic sda_pull, alert_pull, sda_line;
  logic [7:0] ctrl_bits;
  int checks = 0, fails = 0;
  logic cmp_en = 1'b0;
  logic [7:0] m_ctrl = 8'h10, m_pin = 8'h00;
  logic m_pend = 1'b0;

  always #10 clk = ~clk;
  assign sda_line = m_sda & ~sda_pull;

  smb_mon_slave i_smb_mon_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line), .sda_pull(sda_pull),
    .adr_sel(2'b10), .fault_flags(fault_flags), .source_code(source_code),
    .adin_code(adin_code), .fault_evt(fault_evt), .ctrl_bits(ctrl_bits),
    .alert_pull(alert_pull));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle reference comparison of the register and alert outputs
  always @(posedge clk) begin
    #5;
    if (cmp_en && rst_n) begin
      chk("R2 per-cycle ctrl_bits", ctrl_bits, m_ctrl);
      chk("R7 per-cycle alert_pull", alert_pull, m_pend | m_pin[6]);
      chk("R11 per-cycle sda idle", sda_pull, 1'b0);
    end
  end

  task automatic wq; repeat (Q) @(negedge clk); endtask
  task automatic bit_w(input logic b);
    m_sda = b; wq; scl = 1'b1; wq; wq; scl = 1'b0; wq;
  endtask
  task automatic bit_r(output logic b);
    m_sda = 1'b1; wq; scl = 1'b1; wq; b = sda_line; wq; scl = 1'b0; wq;
  endtask
  task automatic b_start; m_sda = 1'b1; scl = 1'b1; wq; m_sda = 1'b0; wq; scl = 1'b0; wq; endtask
  task automatic b_rstart; m_sda = 1'b1; wq; scl = 1'b1; wq; m_sda = 1'b0; wq; scl = 1'b0; wq; endtask
  task automatic b_stop; m_sda = 1'b0; wq; scl = 1'b1; wq; m_sda = 1'b1; wq; endtask
  task automatic byte_w(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) bit_w(d[i]);
    bit_r(b);
    ack = !b;
  endtask
  task automatic byte_r(input logic give_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) bit_r(d[i]);
    bit_w(!give_ack);
  endtask
  task automatic settle; repeat (3) @(negedge clk); cmp_en = 1'b1; endtask

  task automatic do_wr(input logic [6:0] a, input logic [7:0] c, input logic [7:0] d,
                       input logic extra, output logic ack_a, output logic ack_all);
    logic k1, k2, k3;
    cmp_en = 1'b0;
    k1 = 1'b0; k2 = 1'b0; k3 = 1'b1;
    b_start;
    byte_w({a, 1'b0}, ack_a);
    if (ack_a) begin
      byte_w(c, k1);
      byte_w(d, k2);
      if (extra) byte_w(8'hFF, k3);
    end
    b_stop;
    ack_all = ack_a & k1 & k2 & k3;
  endtask

  task automatic do_rd(input logic [6:0] a, input logic [7:0] c,
                       output logic ack_all, output logic [7:0] d);
    logic k0, k1, k2;
    cmp_en = 1'b0;
    d = 8'hXX;
    b_start;
    byte_w({a, 1'b0}, k0);
    byte_w(c, k1);
    b_rstart;
    byte_w({a, 1'b1}, k2);
    if (k2) byte_r(1'b0, d);
    b_stop;
    ack_all = k0 & k1 & k2;
  endtask

  task automatic do_ara(input logic hit_clear, output logic ack, output logic [7:0] d);
    logic b;
    cmp_en = 1'b0;
    d = 8'h00;
    b_start;
    byte_w({7'h0C, 1'b1}, ack);
    if (ack) begin
      for (int i = 7; i >= 1; i--) bit_r(d[i]);
      m_sda = 1'b1; wq; scl = 1'b1; wq; d[0] = sda_line; wq; scl = 1'b0;
      if (hit_clear) begin
        @(posedge clk); @(posedge clk); @(negedge clk); fault_evt = 1'b1;
        @(posedge clk); @(negedge clk); fault_evt = 1'b0;
      end
      wq;
      bit_w(1'b1);
    end
    b_stop;
  endtask

  task automatic pulse_evt;
    cmp_en = 1'b0;
    @(negedge clk); fault_evt = 1'b1;
    @(negedge clk); fault_evt = 1'b0;
    m_pend = 1'b1;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic ka, kall;
    logic [7:0] d;
    repeat (4) @(negedge clk);
    chk("R2 reset ctrl_bits", ctrl_bits, 8'h10);
    chk("R7 reset alert_pull", alert_pull, 1'b0);
    chk("R11 reset sda_pull", sda_pull, 1'b0);
    rst_n = 1'b1;
    settle;

    do_wr(OWN, 8'h00, 8'hB6, 1'b0, ka, kall);
    chk("R1 own write acked", kall, 1'b1);
    m_ctrl = 8'hB6; settle;

    do_wr(7'h45, 8'h00, 8'h00, 1'b0, ka, kall);
    chk("R1 foreign address nack", ka, 1'b0);
    settle;

    do_rd(OWN, 8'h00, kall, d);
    chk("R4 read ctrl ack", kall, 1'b1);
    chk("R4 read ctrl", d, 8'hB6);
    do_rd(OWN, 8'h05, kall, d); chk("R4 read source", d, 8'h9C);
    do_rd(OWN, 8'h06, kall, d); chk("R4 read adin", d, 8'h3D);
    do_rd(OWN, 8'h04, kall, d); chk("R4 read faults", d, 8'h21);
    source_code = 8'h07;
    do_rd(OWN, 8'h05, kall, d); chk("R4 read source live", d, 8'h07);
    settle;

    do_wr(OWN, 8'h03, 8'h02, 1'b1, ka, kall);
    chk("R3 write-word all acked", kall, 1'b1);
    m_pin = 8'h02; settle;
    do_rd(OWN, 8'h03, kall, d); chk("R3 second byte ignored", d, 8'h02);
    settle;

    do_wr(OWN, 8'h09, 8'h77, 1'b0, ka, kall);
    chk("R5 unimplemented write acked", kall, 1'b1);
    do_rd(OWN, 8'h09, kall, d); chk("R5 unimplemented reads zero", d, 8'h00);
    do_rd(OWN, 8'h00, kall, d); chk("R5 ctrl untouched", d, 8'hB6);
    do_rd(OWN, 8'h03, kall, d); chk("R5 pincfg untouched", d, 8'h02);
    settle;

    do_wr(7'h5F, 8'h00, 8'h93, 1'b0, ka, kall);
    chk("R6 mass write acked when enabled", kall, 1'b1);
    m_ctrl = 8'h93; settle;
    do_wr(OWN, 8'h00, 8'h83, 1'b0, ka, kall);
    m_ctrl = 8'h83; settle;
    do_wr(7'h5F, 8'h00, 8'h55, 1'b0, ka, kall);
    chk("R6 mass write nack when disabled", ka, 1'b0);
    settle;
    chk("R6 ctrl unchanged after refused mass", ctrl_bits, 8'h83);
    do_wr(OWN, 8'h00, 8'h90, 1'b0, ka, kall);
    m_ctrl = 8'h90; settle;

    do_ara(1'b0, ka, d);
    chk("R9 ARA nack with nothing pending", ka, 1'b0);
    settle;
    do_wr(OWN, 8'h03, 8'h40, 1'b0, ka, kall);
    m_pin = 8'h40; settle;
    chk("R7 forced pin pulls alert", alert_pull, 1'b1);
    do_ara(1'b0, ka, d);
    chk("R9 ARA nack when only forced", ka, 1'b0);
    settle;
    do_wr(OWN, 8'h03, 8'h00, 1'b0, ka, kall);
    m_pin = 8'h00; settle;

    pulse_evt; settle;
    chk("R7 fault raises alert", alert_pull, 1'b1);
    do_ara(1'b0, ka, d);
    chk("R8 ARA acked when pending", ka, 1'b1);
    chk("R8 ARA returns own address", d, {OWN, 1'b0});
    m_pend = 1'b0; settle;
    chk("R8 alert released after reply", alert_pull, 1'b0);

    do_wr(OWN, 8'h03, 8'h40, 1'b0, ka, kall);
    m_pin = 8'h40; settle;
    pulse_evt; settle;
    do_ara(1'b0, ka, d);
    chk("R8 ARA acked with pending and forced", ka, 1'b1);
    m_pend = 1'b0; settle;
    chk("R8 forced pin holds alert after clear", alert_pull, 1'b1);
    do_wr(OWN, 8'h03, 8'h00, 1'b0, ka, kall);
    m_pin = 8'h00; settle;
    chk("R8 alert low once force removed", alert_pull, 1'b0);

    pulse_evt; settle;
    do_ara(1'b1, ka, d);
    chk("R10 ARA acked", ka, 1'b1);
    settle;
    chk("R10 event in clear cycle keeps alert", alert_pull, 1'b1);
    do_ara(1'b0, ka, d);
    chk("R10 request still answerable", ka, 1'b1);
    m_pend = 1'b0; settle;

    cmp_en = 1'b0;
    b_start; bit_w(1'b1); bit_w(1'b0); bit_w(1'b0); b_stop;
    settle;
    chk("R11 stop mid-byte leaves bus free", sda_pull, 1'b0);
    do_rd(OWN, 8'h00, kall, d);
    chk("R11 transaction after aborted byte", d, 8'h90);
    settle;

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule